// File: doc/BRIEF.md
# Instruction Decoder with Next-PC Selection

This block sits at the front of a simple load/store processor core. It takes a 32-bit instruction word together with the address it was fetched from. It splits the word into its register and immediate fields and classifies it by format. It also works out the address of the instruction that executes next. That address can come from a conditional or unconditional branch, a subroutine call, a register-indirect jump, or plain sequential flow.

The block is purely combinational and holds no state. Branch conditions are evaluated against the four condition flags supplied by the core. The register-indirect jump takes its target from the ALU, which adds the first source register to the second operand. Calls and jumps ask the register file to save the address of the current instruction: a call saves it in register 15, and a jump saves it in the destination named by the instruction. The register file and the ALU sit outside this block.

Top module: `isa_decode_npc`

## Requirements
- R1: `fmt` equals instruction bits 31:30 (0 = sethi/branch, 1 = call, 2 = arithmetic, 3 = memory). `rd` is bits 29:25, `rs1` is bits 18:14, `rs2` is bits 4:0 and `imm_sel` is bit 13, for every instruction word.
- R2: `simm` is bits 12:0 sign extended from bit 12 to 32 bits.
- R3: A branch has fmt 0, bits 24:22 = 010 and bit 29 = 0. Its condition is bits 28:25, coded as follows:
  - 0001 tests z, 0101 tests c, 0110 tests n, 0111 tests v, and 1000 always branches.
  - Flags arrive on `flags_nzvc` with n in bit 3, z in bit 2, v in bit 1 and c in bit 0.
  - When the branch is taken, `next_pc` = `pc` + 4 × (bits 21:0 sign extended from bit 21).
- R4: A recognised branch whose tested flag is 0 gives `next_pc` = `pc` + 4.
- R5: A call (fmt 1) gives `next_pc` = `pc` + 4 × (bits 29:0 sign extended from bit 29). It also raises `link_we` with `link_idx` = 15.
- R6: A jump-and-link (fmt 2, bits 24:19 = 111000) gives `next_pc` = `jmp_target`. It sets `link_idx` = `rd`, and `link_we` is high only when `rd` is not 0, because writes to register 0 are dropped.
- R7: The following instructions give `next_pc` = `pc` + 4 and `link_we` = 0:
  - sethi: fmt 0 with bits 24:22 = 100.
  - Arithmetic with bits 24:19 set to one of 010000, 010001, 010010, 010110 or 100110.
  - Load and store: fmt 3 with bits 24:19 = 000000 or 000100.
- R8: The following encodings raise `illegal` and give `next_pc` = `pc` + 4 and `link_we` = 0:
  - a fmt-0 sub-opcode other than 010 or 100;
  - a branch with bit 29 set;
  - a branch condition not listed in R3;
  - an arithmetic or memory opcode not listed in R6 and R7.
  
  Every other word keeps `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| flags_nzvc | input | 4 | Condition flags n, z, v, c (bit 3 down to 0) |
| jmp_target | input | 32 | Jump address computed by the ALU |
| fmt | output | 2 | Format class |
| rd | output | 5 | Destination (or store source) register field |
| rs1 | output | 5 | First source register field |
| rs2 | output | 5 | Second source register field |
| imm_sel | output | 1 | Immediate select bit |
| simm | output | 32 | Sign-extended 13-bit immediate |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Request to write `pc` into register `link_idx` |
| link_idx | output | 5 | Register that receives the link value |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The bench drives backward displacements at the sign bit of each displacement field, because a wrong extension turns a short backward branch or call into a far forward jump. It covers jump-and-link with destination 0, where a design that ignores the zero-register rule would corrupt register 0. It also sends branches with bit 29 set and condition codes next to the listed ones, which a loose decoder would treat as taken or never-taken branches instead of flagging them. Each condition code is checked with only its own flag set and with only the other three set, so a condition wired to the wrong flag changes the next address.

// File: rtl/isa_decode_pkg.sv
package isa_decode_pkg;

    localparam int XLEN      = 32;
    localparam int REG_W     = 5;
    localparam int LINK_REG  = 15;
    localparam int SIMM_W    = 13;
    localparam int BDISP_W   = 22;
    localparam int CDISP_W   = 30;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    localparam logic [2:0] SUB_BRANCH = 3'b010;
    localparam logic [2:0] SUB_SETHI  = 3'b100;

    localparam logic [5:0] OPC_ADD  = 6'b010000;
    localparam logic [5:0] OPC_AND  = 6'b010001;
    localparam logic [5:0] OPC_OR   = 6'b010010;
    localparam logic [5:0] OPC_NOR  = 6'b010110;
    localparam logic [5:0] OPC_SHR  = 6'b100110;
    localparam logic [5:0] OPC_JAL  = 6'b111000;
    localparam logic [5:0] OPC_LOAD = 6'b000000;
    localparam logic [5:0] OPC_STOR = 6'b000100;

    localparam logic [3:0] CND_EQ  = 4'b0001;
    localparam logic [3:0] CND_CS  = 4'b0101;
    localparam logic [3:0] CND_NEG = 4'b0110;
    localparam logic [3:0] CND_VS  = 4'b0111;
    localparam logic [3:0] CND_AL  = 4'b1000;

    typedef enum logic [1:0] {
        FMT_SB   = 2'b00,
        FMT_CALL = 2'b01,
        FMT_ALU  = 2'b10,
        FMT_MEM  = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        K_NONE, K_BRANCH, K_SETHI, K_CALL, K_ALU, K_JAL, K_LOAD, K_STORE
    } kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        fmt_e               fmt;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic               imm_sel;
        logic [XLEN-1:0]    simm;
        logic [3:0]         cond;
        logic [BDISP_W-1:0] bdisp;
        logic [CDISP_W-1:0] cdisp;
    } fields_t;

    function automatic logic cond_known(input logic [3:0] cnd);
        return (cnd == CND_EQ) || (cnd == CND_CS) || (cnd == CND_NEG) ||
               (cnd == CND_VS) || (cnd == CND_AL);
    endfunction

    function automatic logic [XLEN-1:0] branch_offset(input logic [BDISP_W-1:0] d);
        return {{(XLEN-BDISP_W-2){d[BDISP_W-1]}}, d, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] call_offset(input logic [CDISP_W-1:0] d);
        return {d, 2'b00};
    endfunction

endpackage

// File: rtl/insn_field_decode.sv
module insn_field_decode
    import isa_decode_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output fields_t         fields,
    output kind_e           kind,
    output logic            illegal
);
    logic [2:0] sub_op;
    logic [5:0] opc;

    assign sub_op = insn[24:22];
    assign opc    = insn[24:19];

    always_comb begin
        fields.fmt     = fmt_e'(insn[31:30]);
        fields.rd      = insn[29:25];
        fields.rs1     = insn[18:14];
        fields.rs2     = insn[4:0];
        fields.imm_sel = insn[13];
        fields.simm    = {{(XLEN-SIMM_W){insn[SIMM_W-1]}}, insn[SIMM_W-1:0]};
        fields.cond    = insn[28:25];
        fields.bdisp   = insn[BDISP_W-1:0];
        fields.cdisp   = insn[CDISP_W-1:0];
    end

    always_comb begin
        kind    = K_NONE;
        illegal = 1'b0;
        unique case (fields.fmt)
            FMT_SB: begin
                if (sub_op == SUB_SETHI)
                    kind = K_SETHI;
                else if (sub_op == SUB_BRANCH && !insn[29] && cond_known(insn[28:25]))
                    kind = K_BRANCH;
                else
                    illegal = 1'b1;
            end
            FMT_CALL: kind = K_CALL;
            FMT_ALU: begin
                if (opc == OPC_JAL)
                    kind = K_JAL;
                else if (opc == OPC_ADD || opc == OPC_AND || opc == OPC_OR ||
                         opc == OPC_NOR || opc == OPC_SHR)
                    kind = K_ALU;
                else
                    illegal = 1'b1;
            end
            FMT_MEM: begin
                if (opc == OPC_LOAD)
                    kind = K_LOAD;
                else if (opc == OPC_STOR)
                    kind = K_STORE;
                else
                    illegal = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import isa_decode_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     flags,
    output logic       taken
);
    always_comb begin
        unique case (cond)
            CND_EQ:  taken = flags.z;
            CND_CS:  taken = flags.c;
            CND_NEG: taken = flags.n;
            CND_VS:  taken = flags.v;
            CND_AL:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/next_pc_select.sv
module next_pc_select
    import isa_decode_pkg::*;
(
    input  kind_e              kind,
    input  logic               illegal,
    input  logic               taken,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    jmp_target,
    input  logic [REG_W-1:0]   rd,
    input  logic [BDISP_W-1:0] bdisp,
    input  logic [CDISP_W-1:0] cdisp,
    output logic [XLEN-1:0]    next_pc,
    output logic               link_we,
    output logic [REG_W-1:0]   link_idx
);
    logic [XLEN-1:0] seq_pc;
    assign seq_pc = pc + STEP;

    always_comb begin
        next_pc  = seq_pc;
        link_we  = 1'b0;
        link_idx = '0;
        unique case (kind)
            K_BRANCH: next_pc = taken ? pc + branch_offset(bdisp) : seq_pc;
            K_CALL: begin
                next_pc  = pc + call_offset(cdisp);
                link_we  = 1'b1;
                link_idx = REG_W'(LINK_REG);
            end
            K_JAL: begin
                next_pc  = jmp_target;
                link_idx = rd;
                link_we  = (rd != '0);
            end
            default: next_pc = seq_pc;
        endcase
    end

    // Checks relating decoder, condition and selection outputs
    always_comb begin
        p_zero_reg_write_r6: assert (!link_we || link_idx != '0);
        p_illegal_quiet_r8: assert (!illegal || (!link_we && next_pc == pc + STEP));
        p_untaken_seq_r4: assert (!(kind == K_BRANCH && !taken) || next_pc == pc + STEP);
        p_plain_seq_r7: assert (!(kind == K_SETHI || kind == K_ALU || kind == K_LOAD ||
                                  kind == K_STORE) || (next_pc == pc + STEP && !link_we));
    end
endmodule

// File: rtl/isa_decode_npc.sv
module isa_decode_npc
    import isa_decode_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [31:0] pc,
    input  logic [3:0]  flags_nzvc,
    input  logic [31:0] jmp_target,
    output logic [1:0]  fmt,
    output logic [4:0]  rd,
    output logic [4:0]  rs1,
    output logic [4:0]  rs2,
    output logic        imm_sel,
    output logic [31:0] simm,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic        illegal
);
    fields_t f;
    kind_e   kind;
    logic    taken;

    insn_field_decode u_dec (
        .insn    (insn),
        .fields  (f),
        .kind    (kind),
        .illegal (illegal)
    );

    branch_cond_eval u_cond (
        .cond  (f.cond),
        .flags (flags_t'(flags_nzvc)),
        .taken (taken)
    );

    next_pc_select u_npc (
        .kind       (kind),
        .illegal    (illegal),
        .taken      (taken),
        .pc         (pc),
        .jmp_target (jmp_target),
        .rd         (f.rd),
        .bdisp      (f.bdisp),
        .cdisp      (f.cdisp),
        .next_pc    (next_pc),
        .link_we    (link_we),
        .link_idx   (link_idx)
    );

    assign fmt     = f.fmt;
    assign rd      = f.rd;
    assign rs1     = f.rs1;
    assign rs2     = f.rs2;
    assign imm_sel = f.imm_sel;
    assign simm    = f.simm;

    always_comb begin
        p_call_link_r5: assert (!(fmt == 2'b01) || (link_we && link_idx == 5'd15));
        p_fmt_field_r1: assert (fmt == insn[31:30]);
    end
endmodule

// File: tb/isa_decode_npc_test.sv
module isa_decode_npc_test;

    logic        clk = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] pc = '0;
    logic [3:0]  flags_nzvc = '0;
    logic [31:0] jmp_target = '0;
    logic [1:0]  fmt;
    logic [4:0]  rd, rs1, rs2, link_idx;
    logic        imm_sel, link_we, illegal;
    logic [31:0] simm, next_pc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    isa_decode_npc uut (
        .insn(insn), .pc(pc), .flags_nzvc(flags_nzvc), .jmp_target(jmp_target),
        .fmt(fmt), .rd(rd), .rs1(rs1), .rs2(rs2), .imm_sel(imm_sel), .simm(simm),
        .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx), .illegal(illegal)
    );

    typedef struct packed {
        logic [31:0] npc;
        logic        we;
        logic [4:0]  idx;
        logic        ill;
    } exp_t;

    // Reference built from the requirement text
    function automatic exp_t model(input logic [31:0] w, input logic [31:0] p,
                                   input logic [3:0] fl, input logic [31:0] jt,
                                   output string tag);
        exp_t e;
        logic [5:0] o3;
        logic       t;
        e = '{npc: p + 32'd4, we: 1'b0, idx: 5'd0, ill: 1'b0};
        o3 = w[24:19];
        tag = "R7";
        case (w[31:30])
            2'b00: begin
                if (w[24:22] == 3'b100) tag = "R7";
                else if (w[24:22] == 3'b010 && w[29] == 1'b0 &&
                         (w[28:25] == 4'b0001 || w[28:25] == 4'b0101 || w[28:25] == 4'b0110 ||
                          w[28:25] == 4'b0111 || w[28:25] == 4'b1000)) begin
                    case (w[28:25])
                        4'b0001: t = fl[2];
                        4'b0101: t = fl[0];
                        4'b0110: t = fl[3];
                        4'b0111: t = fl[1];
                        default: t = 1'b1;
                    endcase
                    if (t) begin
                        e.npc = p + ({{10{w[21]}}, w[21:0]} << 2);
                        tag = "R3";
                    end else tag = "R4";
                end else begin
                    e.ill = 1'b1; tag = "R8";
                end
            end
            2'b01: begin
                e.npc = p + ({{2{w[29]}}, w[29:0]} << 2);
                e.we = 1'b1; e.idx = 5'd15; tag = "R5";
            end
            2'b10: begin
                if (o3 == 6'b111000) begin
                    e.npc = jt; e.idx = w[29:25]; e.we = (w[29:25] != 5'd0); tag = "R6";
                end else if (!(o3 == 6'b010000 || o3 == 6'b010001 || o3 == 6'b010010 ||
                               o3 == 6'b010110 || o3 == 6'b100110)) begin
                    e.ill = 1'b1; tag = "R8";
                end
            end
            default: begin
                if (!(o3 == 6'b000000 || o3 == 6'b000100)) begin
                    e.ill = 1'b1; tag = "R8";
                end
            end
        endcase
        return e;
    endfunction

    task automatic apply(input logic [31:0] w, input logic [31:0] p,
                         input logic [3:0] fl, input logic [31:0] jt, input string note);
        exp_t  e;
        string tag;
        @(negedge clk);
        insn = w; pc = p; flags_nzvc = fl; jmp_target = jt;
        #1;
        e = model(w, p, fl, jt, tag);
        checks++;
        if (fmt != w[31:30] || rd != w[29:25] || rs1 != w[18:14] || rs2 != w[4:0] ||
            imm_sel != w[13]) begin
            errors++;
            $display("FAIL R1 %s: fields %h %h %h %h %b expected %h %h %h %h %b", note,
                     fmt, rd, rs1, rs2, imm_sel, w[31:30], w[29:25], w[18:14], w[4:0], w[13]);
        end
        checks++;
        if (simm != {{19{w[12]}}, w[12:0]}) begin
            errors++;
            $display("FAIL R2 %s: simm %h expected %h", note, simm, {{19{w[12]}}, w[12:0]});
        end
        checks++;
        if (next_pc != e.npc || link_we != e.we || (e.we && link_idx != e.idx) ||
            illegal != e.ill) begin
            errors++;
            $display("FAIL %s %s: npc=%h we=%b idx=%0d ill=%b expected npc=%h we=%b idx=%0d ill=%b",
                     tag, note, next_pc, link_we, link_idx, illegal, e.npc, e.we, e.idx, e.ill);
        end
    endtask

    function automatic logic [31:0] mk_branch(input logic [3:0] c, input logic [21:0] d);
        return {2'b00, 1'b0, c, 3'b010, d};
    endfunction

    function automatic logic [31:0] mk_op(input logic [1:0] f, input logic [4:0] r,
                                          input logic [5:0] o, input logic [18:0] rest);
        return {f, r, o, rest};
    endfunction

    initial begin : wdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] conds [5] = '{4'b0001, 4'b0101, 4'b0110, 4'b0111, 4'b1000};
        logic [3:0] fbit  [5] = '{4'b0100, 4'b0001, 4'b1000, 4'b0010, 4'b0000};
        logic [5:0] aops  [6] = '{6'b010000, 6'b010001, 6'b010010, 6'b010110, 6'b100110, 6'b111000};
        void'($urandom(32'h5eed_1234));

        // R3 R4: each condition with only its flag, then all other flags
        for (int k = 0; k < 5; k++) begin
            apply(mk_branch(conds[k], 22'd5), 32'h0000_1000, fbit[k], 32'h0, "R3 own flag");
            apply(mk_branch(conds[k], 22'd5), 32'h0000_1000, ~fbit[k], 32'h0, "R4 other flags");
        end
        // R3 backward branch always: -5 words
        apply(32'b00010000101111111111111111111011, 32'h0000_2000, 4'h0, 32'h0, "R3 backward");
        apply(mk_branch(4'b0001, 22'h200000), 32'h8000_0000, 4'b0100, 32'h0, "R3 min disp");
        // R5 calls forward and backward
        apply(32'b01000000000000000000000000011001, 32'h0000_0800, 4'h0, 32'h0, "R5 fwd");
        apply({2'b01, 30'h3FFF_FFFF}, 32'h0000_0800, 4'h0, 32'h0, "R5 back one");
        apply({2'b01, 30'h2000_0000}, 32'h4000_0000, 4'h0, 32'h0, "R5 sign bit");
        // R6 jump-and-link
        apply(mk_op(2'b10, 5'd0, 6'b111000, 19'h7C004), 32'h100, 4'h0, 32'h1234_5678, "R6 rd0");
        apply(mk_op(2'b10, 5'd15, 6'b111000, 19'h0), 32'h100, 4'h0, 32'hCAFE_0000, "R6 rd15");
        apply(mk_op(2'b10, 5'd31, 6'b111000, 19'h0), 32'h100, 4'h0, 32'h0000_0004, "R6 rd31");
        // R7 sequential flow, with flags set to tempt a branch
        apply({2'b00, 5'd1, 3'b100, 22'h304F15}, 32'hFFFF_FFFC, 4'hF, 32'h0, "R7 sethi wrap");
        apply(mk_op(2'b11, 5'd1, 6'b000000, 19'h01810), 32'h40, 4'hF, 32'h0, "R7 load");
        apply(mk_op(2'b11, 5'd1, 6'b000100, 19'h01810), 32'h40, 4'hF, 32'h0, "R7 store");
        apply(mk_op(2'b10, 5'd2, 6'b010000, 19'h01FFF), 32'h40, 4'hF, 32'h0, "R2 R7 neg imm");
        // R8 illegal encodings
        apply(mk_branch(4'b0010, 22'd5), 32'h40, 4'hF, 32'h0, "R8 cond 0010");
        apply(mk_branch(4'b1001, 22'd5), 32'h40, 4'hF, 32'h0, "R8 cond 1001");
        apply(mk_branch(4'b0001, 22'd5) | 32'h2000_0000, 32'h40, 4'hF, 32'h0, "R8 bit29");
        apply({2'b00, 5'd0, 3'b000, 22'd5}, 32'h40, 4'hF, 32'h0, "R8 op2 000");
        apply(mk_op(2'b10, 5'd3, 6'b111001, 19'h0), 32'h40, 4'hF, 32'h99, "R8 op3 near jal");
        apply(mk_op(2'b11, 5'd3, 6'b000001, 19'h0), 32'h40, 4'hF, 32'h0, "R8 mem op3");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            logic [31:0] r;
            int sel;
            r = $urandom();
            w = $urandom();
            sel = int'($urandom() % 8);
            case (sel)
                0, 1: w = {2'b00, 1'b0, conds[$urandom() % 5], 3'b010, r[21:0]};
                2: w[24:22] = 3'b100;
                3: w[31:30] = 2'b01;
                4: begin w[31:30] = 2'b10; w[24:19] = aops[$urandom() % 6]; end
                5: begin w[31:30] = 2'b11; w[24:19] = r[0] ? 6'b000100 : 6'b000000; end
                default: ;
            endcase
            apply(w, {$urandom()} & 32'hFFFF_FFFC, 4'($urandom()), $urandom(), "random R1-mix");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule